// File: doc/BRIEF.md
# Multi-Shape Parallel Substitution Unit

This unit is the table-lookup stage of a cryptographic processor datapath. Each issued operation carries a shape select, a table page and a 48-bit packed operand, and one cycle later the unit returns a 32-bit packed substitution result. The unit covers four shapes: eight 4-bit to 4-bit lookups, eight 6-bit to 4-bit lookups, four byte-to-byte lookups, or one byte expanded to a 32-bit word. All four shapes are served by the same four byte-wide table lanes.

The tables live in writable storage that is split into pages. A side write port loads one byte entry per cycle. A cipher can keep separate pages for different rounds, or for encryption and decryption, and pick one per operation. An operation that names a page that does not exist returns zero and flags an error for that result.

Top module: `sbox_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `out_vld`, `out_err` and `out_data` are all zero.
- R2: A lookup issued with `in_vld` high produces `out_vld` high exactly one clock later, and a new lookup is accepted in every cycle. `out_vld` is low in the cycle after one with `in_vld` low.
- R3: With `in_mode` = 2'b00, group g (0..7) takes `in_opnd[4g+3:4g]` as an address into lane g/2 of the page. Even groups return the low nibble of that entry and odd groups return the high nibble. The value goes to `out_data[4g+3:4g]`.
- R4: With `in_mode` = 2'b01, group g (0..7) takes `in_opnd[6g+5:6g]` as an address into lane g/2. The nibble choice and the output position are the same as in R3.
- R5: With `in_mode` = 2'b10, byte k (0..3) of `in_opnd` addresses lane k, and the entry goes to `out_data[8k+7:8k]`.
- R6: With `in_mode` = 2'b11, `in_opnd[7:0]` addresses all four lanes, and lane k fills `out_data[8k+7:8k]`.
- R7: Operand bits above those named in R3, R5 or R6 have no effect on the result.
- R8: `in_page` selects one of `PAGES` independent table sets. The same operand on different pages reads that page's own entries.
- R9: A write with `tw_en` high stores `tw_data` at (`tw_page`, `tw_lane`, `tw_addr`). A lookup issued in the next cycle sees the new value. A lookup issued in the same cycle as the write sees the old value.
- R10: A lookup whose `in_page` >= `PAGES` returns `out_data` = 0 with `out_err` high for that result. A write whose `tw_page` >= `PAGES` changes no entry.
- R11: When `out_vld` is low, `out_data` is zero and `out_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Lookup request |
| in_mode | input | 2 | Shape: 00 4-4, 01 6-4, 10 8-8, 11 8-32 |
| in_page | input | 3 | Table page for the lookup |
| in_opnd | input | 48 | Packed lookup operand |
| out_vld | output | 1 | Result valid |
| out_err | output | 1 | Result named a missing page |
| out_data | output | 32 | Packed substitution result |
| tw_en | input | 1 | Table write enable |
| tw_page | input | 3 | Page of the written entry |
| tw_lane | input | 2 | Lane of the written entry |
| tw_addr | input | 8 | Entry address within the lane |
| tw_data | input | 8 | Byte written |

## Verification
Every lookup result, including its valid and error flags, is due in the cycle that follows issue. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is after exactly one rising edge. In the vector walk, lookups are issued back to back, so each check runs while the next lookup is already being driven. The table-write ordering check issues a write and a lookup of the same entry in one cycle and repeats the lookup in the next cycle, expecting the old and then the new byte.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int F6_W   = 6;
  localparam int GROUPS = 2 * LANES;
  localparam int RES_W  = LANES * BYTE_W;
  localparam int OP_W   = GROUPS * F6_W;
  localparam int AW     = BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_N4  = 2'b00,
    MODE_N6  = 2'b01,
    MODE_B8  = 2'b10,
    MODE_W32 = 2'b11
  } sbox_mode_e;

  // 4-bit field of group g, zero-extended to a lane address
  function automatic logic [AW-1:0] nib_addr(input logic [OP_W-1:0] op, input int g);
    return {{(AW-NIB_W){1'b0}}, op[NIB_W*g +: NIB_W]};
  endfunction

  // 6-bit field of group g, zero-extended to a lane address
  function automatic logic [AW-1:0] six_addr(input logic [OP_W-1:0] op, input int g);
    return {{(AW-F6_W){1'b0}}, op[F6_W*g +: F6_W]};
  endfunction

  // byte k of the operand
  function automatic logic [AW-1:0] byte_addr(input logic [OP_W-1:0] op, input int k);
    return op[BYTE_W*k +: BYTE_W];
  endfunction

  function automatic logic nibble_shape(input sbox_mode_e m);
    return (m == MODE_N4) || (m == MODE_N6);
  endfunction

endpackage

// File: rtl/sbox_lane_mem.sv
module sbox_lane_mem
  import sbox_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int PG_IDX_W = $clog2(PAGES),
  localparam int ENTRIES  = 1 << AW,
  localparam int DEPTH    = PAGES * ENTRIES
) (
  input  logic                clk,
  input  logic                we,
  input  logic [PG_IDX_W-1:0] wr_pg,
  input  logic [AW-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [PG_IDX_W-1:0] rd_pg,
  input  logic [AW-1:0]       rd_addr_a,
  input  logic [AW-1:0]       rd_addr_b,
  output logic [BYTE_W-1:0]   rd_data_a,
  output logic [NIB_W-1:0]    rd_hi_b
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wr_pg, wr_addr}] <= wr_data;
  end

  // port A returns the full byte; port B only serves odd nibble groups
  assign rd_data_a = mem[{rd_pg, rd_addr_a}];
  assign rd_hi_b   = mem[{rd_pg, rd_addr_b}][BYTE_W-1 -: NIB_W];

endmodule

// File: rtl/sbox_addr_gen.sv
module sbox_addr_gen
  import sbox_pkg::*;
(
  input  sbox_mode_e                   mode,
  input  logic [OP_W-1:0]              opnd,
  output logic [LANES-1:0][AW-1:0]     addr_a,
  output logic [LANES-1:0][AW-1:0]     addr_b
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      unique case (mode)
        MODE_N4: begin
          addr_a[k] = nib_addr(opnd, 2*k);
          addr_b[k] = nib_addr(opnd, 2*k + 1);
        end
        MODE_N6: begin
          addr_a[k] = six_addr(opnd, 2*k);
          addr_b[k] = six_addr(opnd, 2*k + 1);
        end
        MODE_B8: begin
          addr_a[k] = byte_addr(opnd, k);
          addr_b[k] = byte_addr(opnd, k);
        end
        default: begin
          addr_a[k] = byte_addr(opnd, 0);
          addr_b[k] = byte_addr(opnd, 0);
        end
      endcase
    end
  end

endmodule

// File: rtl/sbox_result_pack.sv
module sbox_result_pack
  import sbox_pkg::*;
(
  input  sbox_mode_e                   mode,
  input  logic [LANES-1:0][BYTE_W-1:0] rd_a,
  input  logic [LANES-1:0][NIB_W-1:0]  rd_b,
  output logic [LANES-1:0][BYTE_W-1:0] res
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (nibble_shape(mode)) res[k] = {rd_b[k], rd_a[k][NIB_W-1:0]};
      else                    res[k] = rd_a[k];
    end
  end

endmodule

// File: rtl/sbox_unit.sv
module sbox_unit
  import sbox_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int PG_IDX_W = $clog2(PAGES),
  localparam int PG_W     = PG_IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [1:0]        in_mode,
  input  logic [PG_W-1:0]   in_page,
  input  logic [OP_W-1:0]   in_opnd,
  output logic              out_vld,
  output logic              out_err,
  output logic [RES_W-1:0]  out_data,
  input  logic              tw_en,
  input  logic [PG_W-1:0]   tw_page,
  input  logic [LANE_W-1:0] tw_lane,
  input  logic [AW-1:0]     tw_addr,
  input  logic [BYTE_W-1:0] tw_data
);

  sbox_mode_e mode;
  assign mode = sbox_mode_e'(in_mode);

  // named internal events
  logic lkp_fire, page_bad, wr_ok;
  assign lkp_fire = in_vld;
  assign page_bad = in_page >= PG_W'(PAGES);
  assign wr_ok    = tw_en && (tw_page < PG_W'(PAGES));

  logic [LANES-1:0][AW-1:0]     addr_a, addr_b;
  logic [LANES-1:0][BYTE_W-1:0] rd_a;
  logic [LANES-1:0][NIB_W-1:0]  rd_b;
  logic [LANES-1:0][BYTE_W-1:0] res_next;

  sbox_addr_gen u_addr (
    .mode   (mode),
    .opnd   (in_opnd),
    .addr_a (addr_a),
    .addr_b (addr_b)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mem
    logic lane_we;
    assign lane_we = wr_ok && (tw_lane == LANE_W'(k));

    sbox_lane_mem #(.PAGES(PAGES)) u_mem (
      .clk       (clk),
      .we        (lane_we),
      .wr_pg     (tw_page[PG_IDX_W-1:0]),
      .wr_addr   (tw_addr),
      .wr_data   (tw_data),
      .rd_pg     (in_page[PG_IDX_W-1:0]),
      .rd_addr_a (addr_a[k]),
      .rd_addr_b (addr_b[k]),
      .rd_data_a (rd_a[k]),
      .rd_hi_b   (rd_b[k])
    );
  end

  sbox_result_pack u_pack (
    .mode (mode),
    .rd_a (rd_a),
    .rd_b (rd_b),
    .res  (res_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_err  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld  <= lkp_fire;
      out_err  <= lkp_fire && page_bad;
      out_data <= (lkp_fire && !page_bad) ? res_next : '0;
    end
  end

endmodule

// File: rtl/sbox_unit_chk.sv
module sbox_unit_chk
  import sbox_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int PG_W = $clog2(PAGES) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [PG_W-1:0]  in_page,
  input logic             out_vld,
  input logic             out_err,
  input logic [RES_W-1:0] out_data
);

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  a_r10_bad_page: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_page >= PG_W'(PAGES)) |=> (out_err && out_data == '0));

  a_r10_good_page: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_page < PG_W'(PAGES)) |=> !out_err);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_data == '0 && !out_err));

endmodule

bind sbox_unit sbox_unit_chk #(.PAGES(PAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_page  (in_page),
  .out_vld  (out_vld),
  .out_err  (out_err),
  .out_data (out_data)
);

// File: tb/test_sbox_unit.sv
`timescale 1ns/1ps
module test_sbox_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic [2:0]  in_page = 3'd0;
  logic [47:0] in_opnd = '0;
  logic        out_vld, out_err;
  logic [31:0] out_data;
  logic        tw_en = 1'b0;
  logic [2:0]  tw_page = 3'd0;
  logic [1:0]  tw_lane = 2'd0;
  logic [7:0]  tw_addr = 8'd0;
  logic [7:0]  tw_data = 8'd0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] shadow [4][4][256];

  always #5 clk = ~clk;

  sbox_unit i_sbox_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
    .in_page(in_page), .in_opnd(in_opnd), .out_vld(out_vld),
    .out_err(out_err), .out_data(out_data), .tw_en(tw_en),
    .tw_page(tw_page), .tw_lane(tw_lane), .tw_addr(tw_addr), .tw_data(tw_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference: rebuilt from the requirement text, group by group
  function automatic logic [31:0] model(input logic [1:0] m, input int pg, input logic [47:0] op);
    logic [31:0] r = '0;
    if (pg > 3) return '0;
    if (m[1] == 1'b0) begin
      for (int g = 0; g < 8; g++) begin
        int a = (m == 2'b00) ? int'((op >> (4*g)) & 48'hF) : int'((op >> (6*g)) & 48'h3F);
        logic [7:0] e = shadow[pg][g/2][a];
        logic [3:0] n = (g % 2 == 1) ? e[7:4] : e[3:0];
        r = r | (32'(n) << (4*g));
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        int a = (m == 2'b10) ? int'((op >> (8*k)) & 48'hFF) : int'(op[7:0]);
        r = r | (32'(shadow[pg][k][a]) << (8*k));
      end
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic lookup(input logic [1:0] m, input int pg, input logic [47:0] op, input string tag);
    logic [31:0] exp = model(m, pg, op);
    @(negedge clk);
    in_vld = 1'b1; in_mode = m; in_page = 3'(pg); in_opnd = op;
    @(negedge clk);
    in_vld = 1'b0;
    chk({tag, " valid"}, 32'(out_vld), 32'd1);
    chk({tag, " data"}, out_data, exp);
    chk({tag, " err"}, 32'(out_err), (pg > 3) ? 32'd1 : 32'd0);
  endtask

  // {mode, page, operand}
  localparam int NV = 9;
  localparam logic [52:0] VEC [NV] = '{
    {2'b00, 3'd0, 48'h0000_7654_3210},
    {2'b00, 3'd3, 48'hFFFF_FEDC_BA98},
    {2'b01, 3'd1, 48'hFC0F_C0FF_03F0},
    {2'b01, 3'd2, 48'h1234_5678_9ABC},
    {2'b10, 3'd0, 48'hABCD_0011_FF80},
    {2'b10, 3'd2, 48'h0000_DEAD_BEEF},
    {2'b11, 3'd1, 48'hFFFF_FFFF_FF00},
    {2'b11, 3'd3, 48'h0000_0000_0042},
    {2'b10, 3'd6, 48'h0000_1234_5678}
  };

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_q [NV];
    logic [31:0] e_old, e_new;
    logic [7:0]  keep;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset vld", 32'(out_vld), 0);
    chk("R1 reset data", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release err", 32'(out_err), 0);

    // load every table entry
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 4; l++)
        for (int a = 0; a < 256; a++) begin
          logic [7:0] v = 8'((a * 37 + l * 101 + p * 59 + 27) ^ (a >> 2));
          @(negedge clk);
          tw_en = 1'b1; tw_page = 3'(p); tw_lane = 2'(l); tw_addr = 8'(a); tw_data = v;
          shadow[p][l][a] = v;
        end
    @(negedge clk);
    tw_en = 1'b0;

    // R2: vector walk, one lookup per cycle
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        logic [1:0] pm = VEC[i-1][52:51];
        chk({"R2 ", mode_tag(pm), " vec data"}, out_data, exp_q[i-1]);
        chk("R2 vec valid", 32'(out_vld), 1);
        chk("R10 vec err", 32'(out_err), (VEC[i-1][50:48] > 3) ? 32'd1 : 32'd0);
      end
      if (i < NV) begin
        exp_q[i] = model(VEC[i][52:51], int'(VEC[i][50:48]), VEC[i][47:0]);
        in_vld = 1'b1; in_mode = VEC[i][52:51]; in_page = VEC[i][50:48]; in_opnd = VEC[i][47:0];
      end else in_vld = 1'b0;
    end
    @(negedge clk);
    chk("R11 idle data", out_data, 0);
    chk("R2 idle vld", 32'(out_vld), 0);

    // R7: upper operand bits ignored
    lookup(2'b00, 2, 48'hA5A5_0000_0000, "R7 n4 upper");
    lookup(2'b11, 0, 48'hFFFF_FFFF_FF17, "R7 w32 upper");
    chk("R7 w32 vs clean", out_data, model(2'b11, 0, 48'h17));

    // R8: pages are independent
    for (int p = 0; p < 4; p++) lookup(2'b10, p, 48'h0000_0304_0506, "R8 page");

    // R9: write/lookup ordering on lane 2, page 1, address 0x33
    keep = shadow[1][2][8'h33] ^ 8'hFF;
    e_old = model(2'b10, 1, 48'h0000_0033_0000);
    @(negedge clk);
    tw_en = 1'b1; tw_page = 3'd1; tw_lane = 2'd2; tw_addr = 8'h33; tw_data = keep;
    in_vld = 1'b1; in_mode = 2'b10; in_page = 3'd1; in_opnd = 48'h0000_0033_0000;
    @(negedge clk);
    tw_en = 1'b0;
    shadow[1][2][8'h33] = keep;
    e_new = model(2'b10, 1, 48'h0000_0033_0000);
    chk("R9 same-cycle old", out_data, e_old);
    @(negedge clk);
    in_vld = 1'b0;
    chk("R9 next-cycle new", out_data, e_new);

    // R10: missing pages
    lookup(2'b00, 5, 48'h0000_1111_1111, "R10 page5");
    lookup(2'b11, 7, 48'h0000_0000_00AA, "R10 page7");
    @(negedge clk);
    tw_en = 1'b1; tw_page = 3'd4; tw_lane = 2'd0; tw_addr = 8'h00; tw_data = ~shadow[0][0][0];
    @(negedge clk);
    tw_en = 1'b0;
    lookup(2'b10, 0, 48'h0, "R10 bad write ignored");

    // R1: reset mid-run clears a pending result
    @(negedge clk);
    in_vld = 1'b1; in_mode = 2'b10; in_page = 3'd0; in_opnd = 48'h1;
    rst_n = 1'b0;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R1 mid reset vld", 32'(out_vld), 0);
    chk("R1 mid reset data", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule